// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

The block is an SPI master that is controlled through a simple 32-bit register bus. Software fills a transmit FIFO by writing words to a data register. It picks the clock polarity, the clock phase, the bit order and an internal loopback path in a control register. It then clears a hold bit, and the shift engine starts. The engine sends words back to back until the transmit FIFO is empty. Each word sent returns one word into the receive FIFO, which software drains by reading a second data register.

The serial clock comes from the system clock through a divider that is fixed when the block is built. Software cannot change its rate. The slave-select pins copy the low bits of a slave-select register, active low. The register bus byte order can be found by writing the loopback bit and reading it back. A write of a key value to a reset offset returns all registers and both FIFOs to their default state.

Top module: `spim_ctrl_top`

## Requirements
- R1: After reset the control register reads 0x100 (hold set, all else clear), the status register reads 0x05 (receive empty at bit 0, transmit empty at bit 2; receive full bit 1, transmit full bit 3 and fault bit 4 clear), and the slave-select register reads 0xFFFFFFFF.
- R2: Writing 0x0000000A to offset 0x40 restores the control register, the slave-select register and both FIFOs to their reset state. Any other value written there has no effect.
- R3: The transmit FIFO (offset 0x68, write) holds FIFO_DEPTH words. When it is full, status bit 3 is set and further writes are dropped, so only the first FIFO_DEPTH words are sent.
- R4: While the hold bit (control bit 8) is set, no word leaves the transmit FIFO, the serial clock does not toggle, and nothing enters the receive FIFO.
- R5: With enable (bit 1) and master (bit 2) set and hold clear, all queued words are sent back to back. Each word makes exactly 2*WORD_W serial-clock transitions and pushes one word into the receive FIFO, which is read and popped at offset 0x6C.
- R6: The serial clock rests at the polarity bit (control bit 3). The input is sampled on the first edge of each bit when the phase bit (control bit 4) is 0 and on the second edge when it is 1. MOSI is stable at every sampling edge.
- R7: With control bit 9 clear, words go out most significant bit first. With it set, they go out least significant bit first. The received word is assembled in the same order.
- R8: With the loopback bit (control bit 0) set, MOSI feeds the receive shifter and the MISO pin is ignored. The loopback bit reads back exactly as it was written.
- R9: Writing control bit 5 empties the transmit FIFO and writing bit 6 empties the receive FIFO. Both bits read back as 0.
- R10: The slave-select pins equal the low NUM_SEL bits of the register at offset 0x70 from the cycle after the write.
- R11: While enable or master is clear, no transfer starts, the serial clock stays at the polarity level and MOSI is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NUM_SEL | Slave selects, active low |

## Verification
The hardest cases to reach from the ports are the sampling instants on the wire in all four clock modes, because the active edge moves with both the polarity and the phase bits. The bench watches the serial clock itself. It rebuilds each word from MOSI on the edges that the requirement calls for, and it ties MISO to the inverse of MOSI, so loopback and pin input give different received words. It also fills the transmit FIFO past its depth while held, then releases it. Random transfers with random modes, bit orders and word counts are then mixed in.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam logic [7:0] OFS_SOFTRST = 8'h40;
   localparam logic [7:0] OFS_CTRL    = 8'h60;
   localparam logic [7:0] OFS_STAT    = 8'h64;
   localparam logic [7:0] OFS_TXD     = 8'h68;
   localparam logic [7:0] OFS_RXD     = 8'h6C;
   localparam logic [7:0] OFS_SEL     = 8'h70;

   localparam logic [31:0] SOFTRST_KEY = 32'h0000_000A;

   localparam int CTRL_W = 10;

   typedef struct packed {
      logic lsb_first;   // bit 9
      logic hold;        // bit 8
      logic man_sel;     // bit 7
      logic rx_clr;      // bit 6 (self-clearing)
      logic tx_clr;      // bit 5 (self-clearing)
      logic cpha;        // bit 4
      logic cpol;        // bit 3
      logic master;      // bit 2
      logic enable;      // bit 1
      logic loop;        // bit 0
   } ctrl_t;

   localparam ctrl_t CTRL_DEFAULT = ctrl_t'(10'h100);
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("spim_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;
   logic [AW:0]  count;
   logic         do_push, do_pop;

   assign empty   = (wp == rp);
   assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp[AW-1:0]];
   assign count   = wp - rp;

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (clr) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> $stable(count)); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !clr) |=> empty); // R5
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty); // R9
endmodule

// File: rtl/spim_shift_eng.sv
module spim_shift_eng #(
   parameter int WORD_W  = 8,
   parameter int CLK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_ok,
   input  logic              hold,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              lsb_first,
   input  logic              loop,
   input  logic              tx_empty,
   input  logic [WORD_W-1:0] tx_data,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_data,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi
);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("spim_shift_eng: CLK_DIV must be at least 1");
      end
   endgenerate

   logic              busy;
   logic              phase;
   logic [DIV_W-1:0]  div_cnt;
   logic [BIT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;
   logic              out_bit, in_bit, half_end, active;

   assign active   = busy && run_ok;
   assign out_bit  = lsb_first ? tx_sh[0] : tx_sh[WORD_W-1];
   assign in_bit   = loop ? out_bit : miso;
   assign half_end = (div_cnt == DIV_LAST);
   assign tx_pop   = run_ok && !busy && !hold && !tx_empty;
   assign rx_push  = active && half_end && phase && (bit_cnt == BIT_LAST);
   assign rx_data  = rx_sh;
   assign mosi     = active && out_bit;
   assign sclk     = cpol ^ (active && (phase ^ cpha));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         phase   <= 1'b0;
         div_cnt <= '0;
         bit_cnt <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
      end else if (!run_ok) begin
         busy    <= 1'b0;
         phase   <= 1'b0;
         div_cnt <= '0;
         bit_cnt <= '0;
      end else if (!busy) begin
         if (tx_pop) begin
            busy    <= 1'b1;
            tx_sh   <= tx_data;
            phase   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
         end
      end else if (half_end) begin
         div_cnt <= '0;
         if (!phase) begin
            phase <= 1'b1;
            rx_sh <= lsb_first ? {in_bit, rx_sh[WORD_W-1:1]}
                               : {rx_sh[WORD_W-2:0], in_bit};
         end else begin
            phase <= 1'b0;
            if (bit_cnt == BIT_LAST) begin
               busy <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               tx_sh   <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
            end
         end
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cpol)); // R6
   AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run_ok |-> !mosi); // R11
   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !busy) |=> !busy); // R4
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({tx_pop, rx_push}) <= 1); // R5
endmodule

// File: rtl/spim_ctrl_top.sv
module spim_ctrl_top
   import spim_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int CLK_DIV    = 2,
   parameter int NUM_SEL    = 4,
   parameter int ADDR_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_en,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               spi_sclk,
   output logic               spi_mosi,
   input  logic               spi_miso,
   output logic [NUM_SEL-1:0] spi_ss_n
);
   generate
      if (WORD_W != 8 && WORD_W != 16 && WORD_W != 32) begin : g_bad_word
         $error("spim_ctrl_top: WORD_W must be 8, 16 or 32");
      end
      if (NUM_SEL < 1 || NUM_SEL > 32) begin : g_bad_sel
         $error("spim_ctrl_top: NUM_SEL must be 1..32");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("spim_ctrl_top: ADDR_W must be at least 8");
      end
   endgenerate

   ctrl_t       ctrl_q;
   logic [31:0] sel_q;

   logic wr, rd;
   logic hit_ctrl, hit_stat, hit_txd, hit_rxd, hit_sel, hit_rst;
   logic soft_rst, tx_clr, rx_clr;

   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic              tx_pop, rx_push;
   logic [WORD_W-1:0] tx_dout, rx_dout, rx_word;
   logic [31:0]       rx_word32;

   assign wr       = bus_en && bus_we;
   assign rd       = bus_en && !bus_we;
   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_txd  = (bus_addr == ADDR_W'(OFS_TXD));
   assign hit_rxd  = (bus_addr == ADDR_W'(OFS_RXD));
   assign hit_sel  = (bus_addr == ADDR_W'(OFS_SEL));
   assign hit_rst  = (bus_addr == ADDR_W'(OFS_SOFTRST));

   assign soft_rst = wr && hit_rst && (bus_wdata == SOFTRST_KEY);
   assign tx_clr   = soft_rst || (wr && hit_ctrl && bus_wdata[5]);
   assign rx_clr   = soft_rst || (wr && hit_ctrl && bus_wdata[6]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_DEFAULT;
         sel_q  <= '1;
      end else if (soft_rst) begin
         ctrl_q <= CTRL_DEFAULT;
         sel_q  <= '1;
      end else if (wr) begin
         if (hit_ctrl) begin
            ctrl_q        <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            ctrl_q.tx_clr <= 1'b0;
            ctrl_q.rx_clr <= 1'b0;
         end
         if (hit_sel) sel_q <= bus_wdata;
      end
   end

   assign spi_ss_n = sel_q[NUM_SEL-1:0];

   spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tx_clr),
      .push  (wr && hit_txd),
      .din   (bus_wdata[WORD_W-1:0]),
      .pop   (tx_pop),
      .dout  (tx_dout),
      .empty (tx_empty),
      .full  (tx_full)
   );

   spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_clr),
      .push  (rx_push),
      .din   (rx_word),
      .pop   (rd && hit_rxd),
      .dout  (rx_dout),
      .empty (rx_empty),
      .full  (rx_full)
   );

   spim_shift_eng #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_ok    (ctrl_q.enable && ctrl_q.master),
      .hold      (ctrl_q.hold),
      .cpol      (ctrl_q.cpol),
      .cpha      (ctrl_q.cpha),
      .lsb_first (ctrl_q.lsb_first),
      .loop      (ctrl_q.loop),
      .tx_empty  (tx_empty),
      .tx_data   (tx_dout),
      .tx_pop    (tx_pop),
      .rx_push   (rx_push),
      .rx_data   (rx_word),
      .miso      (spi_miso),
      .sclk      (spi_sclk),
      .mosi      (spi_mosi)
   );

   generate
      if (WORD_W < 32) begin : g_rx_ext
         assign rx_word32 = {{(32 - WORD_W){1'b0}}, rx_dout};
      end else begin : g_rx_full
         assign rx_word32 = rx_dout;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl)      bus_rdata = {{(32 - CTRL_W){1'b0}}, ctrl_q};
      else if (hit_stat) bus_rdata = {27'b0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
      else if (hit_rxd)  bus_rdata = rx_word32;
      else if (hit_sel)  bus_rdata = sel_q;
   end

   AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_sel && !soft_rst) |=> (spi_ss_n == $past(bus_wdata[NUM_SEL-1:0]))); // R10
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_q == CTRL_DEFAULT && sel_q == '1 && tx_empty && rx_empty)); // R2
   AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.tx_clr && !ctrl_q.rx_clr)); // R9
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_q.enable && ctrl_q.master) |-> (spi_sclk == ctrl_q.cpol && !tx_pop)); // R11
endmodule

// File: tb/spim_ctrl_top_tb.sv
module spim_ctrl_top_tb_top;
   localparam int W     = 8;
   localparam int DEPTH = 16;
   localparam int DIV   = 2;
   localparam int NSEL  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sclk, spi_mosi, spi_miso;
   logic [NSEL-1:0] spi_ss_n;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   assign spi_miso = ~spi_mosi;

   spim_ctrl_top #(.WORD_W(W), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV),
                   .NUM_SEL(NSEL), .ADDR_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_ss_n(spi_ss_n)
   );

   // wire monitor
   bit         cap_on = 0;
   logic       b_cpol = 0, b_cpha = 0, b_lsb = 0;
   int         edge_cnt = 0, cap_n = 0;
   logic [W-1:0] cap_sh = '0;
   logic [W-1:0] cap_q [$];

   always @(spi_sclk) begin
      if (cap_on) begin
         edge_cnt++;
         if (spi_sclk === (b_cpol ^ ~b_cpha)) begin
            cap_sh = b_lsb ? {spi_mosi, cap_sh[W-1:1]} : {cap_sh[W-2:0], spi_mosi};
            cap_n++;
            if (cap_n == W) begin
               cap_q.push_back(cap_sh);
               cap_n = 0;
            end
         end
      end
   end

   task automatic mon_clear();
      edge_cnt = 0; cap_n = 0; cap_q.delete(); cap_on = 1;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 0; bus_we = 0;
   endtask

   task automatic bread(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 0;
   endtask

   function automatic logic [31:0] mk_ctrl(bit en, bit ms, bit cpol, bit cpha,
                                           bit lsb, bit lp, bit hold);
      return {22'b0, lsb, hold, 1'b0, 2'b00, cpha, cpol, ms, en, lp};
   endfunction

   function automatic logic [31:0] mk_stat(bit rxe, bit rxf, bit txe, bit txf);
      return {27'b0, 1'b0, txf, txe, rxf, rxe};
   endfunction

   function automatic logic [W-1:0] exp_rx(logic [W-1:0] tx, bit lp);
      return lp ? tx : ~tx;
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // full transfer: load words held, release, check wire and receive data
   task automatic run_xfer(input bit cpol, input bit cpha, input bit lsb,
                           input bit lp, input int n);
      logic [W-1:0] words [$];
      logic [31:0]  r;
      logic [31:0]  cv;
      cap_on = 0;
      b_cpol = cpol; b_cpha = cpha; b_lsb = lsb;
      cv = mk_ctrl(1, 1, cpol, cpha, lsb, lp, 1);
      bwrite(8'h60, cv);
      for (int i = 0; i < n; i++) begin
         logic [W-1:0] w;
         w = W'($urandom);
         words.push_back(w);
         bwrite(8'h68, {24'b0, w});
      end
      wait_cyc(3 * DIV * W);
      mon_clear();
      chk(edge_cnt == 0, "R4 held clock quiet", edge_cnt, 0);
      bwrite(8'h60, cv & ~32'h100);
      wait_cyc(n * (2 * DIV * W + 3) + 10);
      bwrite(8'h60, cv);
      cap_on = 0;
      chk(edge_cnt == 2 * W * n, "R5 clock edges per run", edge_cnt, 2 * W * n);
      chk(spi_sclk == cpol, "R6 clock rests at polarity", spi_sclk, cpol);
      chk(cap_q.size() == n, "R5 words on wire", cap_q.size(), n);
      for (int i = 0; i < n && i < cap_q.size(); i++)
         chk(cap_q[i] == words[i], lsb ? "R7 lsb-first wire word" : "R6 msb-first wire word",
             cap_q[i], words[i]);
      for (int i = 0; i < n; i++) begin
         bread(8'h6C, r);
         chk(r == {24'b0, exp_rx(words[i], lp)}, lp ? "R8 loopback receive" : "R5 receive word",
             r, {24'b0, exp_rx(words[i], lp)});
      end
      bread(8'h64, r);
      chk(r == mk_stat(1, 0, 1, 0), "R5 fifos drained", r, mk_stat(1, 0, 1, 0));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      bread(8'h60, r); chk(r == 32'h100, "R1 control default", r, 32'h100);
      bread(8'h64, r); chk(r == mk_stat(1, 0, 1, 0), "R1 status default", r, mk_stat(1, 0, 1, 0));
      bread(8'h70, r); chk(r == 32'hFFFF_FFFF, "R1 select default", r, 32'hFFFF_FFFF);
      chk(spi_ss_n == '1, "R1 select pins", spi_ss_n, 4'hF);
      chk(spi_sclk == 0 && spi_mosi == 0, "R11 idle pins", {spi_sclk, spi_mosi}, 0);

      // R10 select register drives pins
      for (int i = 0; i < 4; i++) begin
         logic [31:0] v;
         v = $urandom;
         bwrite(8'h70, v);
         chk(spi_ss_n == v[NSEL-1:0], "R10 select pins", spi_ss_n, v[NSEL-1:0]);
         bread(8'h70, r); chk(r == v, "R10 select readback", r, v);
      end

      // R8 loopback bit probe
      bwrite(8'h60, mk_ctrl(0, 0, 0, 0, 0, 1, 1));
      bread(8'h60, r); chk(r == mk_ctrl(0, 0, 0, 0, 0, 1, 1), "R8 loop bit readback", r, mk_ctrl(0, 0, 0, 0, 0, 1, 1));

      // R11 disabled: no transfer, clock at polarity, MOSI low
      b_cpol = 1; b_cpha = 0; b_lsb = 0;
      bwrite(8'h60, mk_ctrl(1, 0, 1, 0, 0, 0, 0));
      mon_clear();
      bwrite(8'h68, 32'hFF);
      wait_cyc(4 * DIV * W);
      chk(edge_cnt == 0, "R11 no clock without master", edge_cnt, 0);
      chk(spi_sclk == 1 && spi_mosi == 0, "R11 pins while off", {spi_sclk, spi_mosi}, 2'b10);
      bread(8'h64, r); chk(r == mk_stat(1, 0, 0, 0), "R11 word stays queued", r, mk_stat(1, 0, 0, 0));
      cap_on = 0;
      // R9 transmit clear
      bwrite(8'h60, mk_ctrl(1, 0, 1, 0, 0, 0, 0) | 32'h20);
      bread(8'h64, r); chk(r == mk_stat(1, 0, 1, 0), "R9 tx clear empties", r, mk_stat(1, 0, 1, 0));
      bread(8'h60, r); chk(r == mk_ctrl(1, 0, 1, 0, 0, 0, 0), "R9 clear bits read 0", r, mk_ctrl(1, 0, 1, 0, 0, 0, 0));

      // R4 hold keeps words in place
      b_cpol = 0;
      bwrite(8'h60, mk_ctrl(1, 1, 0, 0, 0, 0, 1));
      mon_clear();
      for (int i = 0; i < 3; i++) bwrite(8'h68, i + 1);
      wait_cyc(6 * DIV * W);
      chk(edge_cnt == 0, "R4 no clock while held", edge_cnt, 0);
      bread(8'h64, r); chk(r == mk_stat(1, 0, 0, 0), "R4 nothing received", r, mk_stat(1, 0, 0, 0));
      cap_on = 0;
      bwrite(8'h60, mk_ctrl(1, 1, 0, 0, 0, 0, 1) | 32'h20);

      // directed modes: all four clock modes, both orders
      run_xfer(0, 0, 0, 0, 2);
      run_xfer(0, 1, 0, 0, 2);
      run_xfer(1, 0, 1, 0, 2);
      run_xfer(1, 1, 1, 1, 3);

      // R9 receive clear
      bwrite(8'h60, mk_ctrl(1, 1, 0, 0, 0, 1, 1));
      bwrite(8'h68, 32'h5A);
      bwrite(8'h60, mk_ctrl(1, 1, 0, 0, 0, 1, 0));
      wait_cyc(2 * DIV * W + 10);
      bread(8'h64, r); chk(r == mk_stat(0, 0, 1, 0), "R9 word received", r, mk_stat(0, 0, 1, 0));
      bwrite(8'h60, mk_ctrl(1, 1, 0, 0, 0, 1, 1) | 32'h40);
      bread(8'h64, r); chk(r == mk_stat(1, 0, 1, 0), "R9 rx clear empties", r, mk_stat(1, 0, 1, 0));

      // R3 overfill while held
      begin
         logic [W-1:0] ws [$];
         bwrite(8'h60, mk_ctrl(1, 1, 0, 0, 0, 1, 1));
         for (int i = 0; i < DEPTH + 3; i++) begin
            logic [W-1:0] w;
            w = W'($urandom);
            ws.push_back(w);
            bwrite(8'h68, {24'b0, w});
         end
         bread(8'h64, r); chk(r == mk_stat(1, 0, 0, 1), "R3 tx full flag", r, mk_stat(1, 0, 0, 1));
         bwrite(8'h60, mk_ctrl(1, 1, 0, 0, 0, 1, 0));
         wait_cyc(DEPTH * (2 * DIV * W + 3) + 20);
         bread(8'h64, r); chk(r == mk_stat(0, 1, 1, 0), "R3 rx full after run", r, mk_stat(0, 1, 1, 0));
         for (int i = 0; i < DEPTH; i++) begin
            bread(8'h6C, r);
            chk(r == {24'b0, ws[i]}, "R3 first words kept", r, {24'b0, ws[i]});
         end
         bread(8'h64, r); chk(r == mk_stat(1, 0, 1, 0), "R3 extra words dropped", r, mk_stat(1, 0, 1, 0));
      end

      // random transfers
      for (int t = 0; t < 8; t++) begin
         logic [3:0] m;
         m = 4'($urandom);
         run_xfer(m[0], m[1], m[2], m[3], 1 + int'($urandom % 5));
      end

      // R2 soft reset
      bwrite(8'h70, 32'h1234_5670);
      bwrite(8'h60, mk_ctrl(1, 1, 1, 0, 1, 1, 1));
      bwrite(8'h68, 32'h11);
      bwrite(8'h40, 32'h0000_000B);
      bread(8'h60, r); chk(r == mk_ctrl(1, 1, 1, 0, 1, 1, 1), "R2 wrong key ignored", r, mk_ctrl(1, 1, 1, 0, 1, 1, 1));
      bread(8'h64, r); chk(r == mk_stat(1, 0, 0, 0), "R2 wrong key keeps fifo", r, mk_stat(1, 0, 0, 0));
      bwrite(8'h40, 32'h0000_000A);
      bread(8'h60, r); chk(r == 32'h100, "R2 control restored", r, 32'h100);
      bread(8'h70, r); chk(r == 32'hFFFF_FFFF, "R2 select restored", r, 32'hFFFF_FFFF);
      bread(8'h64, r); chk(r == mk_stat(1, 0, 1, 0), "R2 fifos emptied", r, mk_stat(1, 0, 1, 0));
      chk(spi_ss_n == '1, "R2 select pins", spi_ss_n, 4'hF);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule